// File: doc/BRIEF.md
# Assertion-Chain Exception Dispatcher

This block closes the loop on a daisy chain of on-chip assertion cells. Each cell holds one pass/fail bit, and the chain drives a shared, active-low event line whenever any cell has seen a violation. When that line drops, the dispatcher takes over the chain and shifts the cell results out one per clock. It finds the failing cell with the lowest index, looks up the response class that software has programmed for that cell, and fires exactly one of four graded recovery actions for one cycle.

The chain is synchronous to the dispatcher's clock. The scan strobe is a one-cycle-high shift enable, and the chain advances on the clock edge at which the strobe is high. Cell 0 is visible on the serial input as soon as scan enable is active. After the dispatch the block stays disarmed until it sees the event line high again, so a line that stays low produces one dispatch and not a stream of them.

Top module: `aexc_dispatch`

## Requirements
- R1: During reset and after its release, `scan_en_n` is high, `scan_clk` is low, `act` is 0, `spurious` is 0 and `err_idx` is 0.
- R2: While armed, `evt_n` sampled low at a clock edge starts a scan in the next cycle. `scan_en_n` then stays low for exactly N_CELLS consecutive cycles.
- R3: In scan cycle k (k = 0 first), the block reads cell k from `scan_in`, where 0 means failed. `scan_clk` is high in scan cycles 0 to N_CELLS-2 and low in the last one. `scan_clk` is never high while `scan_en_n` is high.
- R4: When at least one cell reads 0, `err_idx` takes the lowest such index in the cycle after the last scan cycle. It holds its value at all other times.
- R5: The response class of cell i is `class_tab[2*i+1:2*i]`. Class c drives `act` bit c: bit 0 halts the processor, bit 1 requests a hardware reset, bit 2 raises a software interrupt, and bit 3 starts the dedicated exception hardware. At most one `act` bit is high at a time.
- R6: `act` is a one-cycle pulse in the cycle right after the last scan cycle. That is the same cycle in which `scan_en_n` returns high. `act` is 0 in every other cycle.
- R7: When no cell reads 0, `spurious` pulses in that same cycle instead. `act` stays 0 and `err_idx` is unchanged.
- R8: After a dispatch, no new scan starts until `evt_n` has been sampled high. An `evt_n` held low produces a single scan.
- R9: Changes on `evt_n` during a scan are ignored, and the scan runs to completion. `evt_n` sampled high in the pulse cycle re-arms the block at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_n | input | 1 | Chain event line, low when any cell has failed |
| scan_in | input | 1 | Serial cell result from the chain, 0 = failed |
| class_tab | input | 2*N_CELLS | Response class per cell, 2 bits each |
| scan_en_n | output | 1 | Scan enable to the chain, active low |
| scan_clk | output | 1 | Shift strobe to the chain, one cycle per shift |
| act | output | 4 | One-hot action pulse |
| spurious | output | 1 | Pulse: event seen but no failing cell found |
| err_idx | output | $clog2(N_CELLS) | Index of the last dispatched failing cell |

## Verification
Two pairs of events can fall in the same cycle. The first pair: a failure held only by the last cell is captured in the same cycle in which the dispatch decision is registered. The bench provokes this by failing only cell N_CELLS-1, and it judges the result by `err_idx` and by the `act` bit its scoreboard predicts. The second pair: re-arming can coincide with the action pulse. The bench raises `evt_n` in exactly the pulse cycle and drops it again one cycle later, then expects a second complete scan and a second correct dispatch. A scan-length monitor also confirms that `evt_n` held low, or toggled mid-scan, never shortens a scan or repeats it.

// File: rtl/aexc_pkg.sv
// Shared types for the assertion-chain exception dispatcher.
// Assumes four response classes, encoded in 2 bits.
package aexc_pkg;

    localparam int N_ACT = 4;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_SCAN  = 2'd1,
        ST_REARM = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_HALT  = 2'd0,
        CLS_HWRST = 2'd1,
        CLS_SWINT = 2'd2,
        CLS_EXCHW = 2'd3
    } resp_class_e;

    // Turn a response class into its one-hot action vector.
    function automatic logic [N_ACT-1:0] class_onehot(input logic [1:0] cls);
        logic [N_ACT-1:0] v;
        v = '0;
        for (int b = 0; b < N_ACT; b++) begin
            if (cls == b[1:0]) v[b] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/aexc_seq.sv
// Scan sequencer: arms on a high event line, starts a scan when the line
// is sampled low, and walks a position counter over N_CELLS cycles. It then
// waits for the line to go high again. Assumes the chain shifts on the
// clock edge at which scan_clk is high.
module aexc_seq #(
    parameter int N_CELLS = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_n,
    output logic             scanning,
    output logic             first,
    output logic             last,
    output logic [IDX_W-1:0] pos,
    output logic             scan_en_n,
    output logic             scan_clk
);
    import aexc_pkg::*;

    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(N_CELLS - 1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] pos_q;

    // State and position counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            pos_q   <= '0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    pos_q <= '0;
                    if (!evt_n) state_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (pos_q == LAST_POS) begin
                        pos_q   <= '0;
                        state_q <= ST_REARM;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                ST_REARM: begin
                    if (evt_n) state_q <= ST_ARMED;
                end
                default: state_q <= ST_ARMED;
            endcase
        end
    end

    // Decoded scan phase and chain controls.
    always_comb begin
        scanning  = (state_q == ST_SCAN);
        first     = scanning && (pos_q == '0);
        last      = scanning && (pos_q == LAST_POS);
        pos       = pos_q;
        scan_en_n = !scanning;
        scan_clk  = scanning && !last;
    end

endmodule

// File: rtl/aexc_capture.sv
// First-failure capture: while scanning, remembers the lowest position at
// which the serial input read 0. It presents the final found/index result
// combinationally, so it is valid in the last scan cycle.
module aexc_capture #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scanning,
    input  logic             first,
    input  logic [IDX_W-1:0] pos,
    input  logic             scan_in,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    logic             hit_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit_prev;
    logic [IDX_W-1:0] idx_prev;

    // Earlier result, cleared at the first position of a scan.
    always_comb begin
        hit_prev = first ? 1'b0 : hit_q;
        idx_prev = first ? '0   : idx_q;
        hit      = hit_prev || !scan_in;
        hit_idx  = hit_prev ? idx_prev : pos;
    end

    // Keep the running lowest-index failure across the scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else if (scanning) begin
            hit_q <= hit;
            idx_q <= hit_idx;
        end
    end

endmodule

// File: rtl/aexc_encode.sv
// Response encoder: at the last scan cycle, looks up the class of the
// captured index and registers a one-cycle action or spurious pulse. It
// also updates the held error index. Assumes 2 class bits per cell.
module aexc_encode #(
    parameter int N_CELLS = 8,
    parameter int IDX_W   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         last,
    input  logic                         hit,
    input  logic [IDX_W-1:0]             hit_idx,
    input  logic [2*N_CELLS-1:0]         class_tab,
    output logic [aexc_pkg::N_ACT-1:0]   act,
    output logic                         spurious,
    output logic [IDX_W-1:0]             err_idx
);
    import aexc_pkg::*;

    logic [1:0]       cls_arr [N_CELLS];
    logic [1:0]       sel_cls;
    logic [N_ACT-1:0] act_q;
    logic             spur_q;
    logic [IDX_W-1:0] idx_q;

    // Unpack the flat class table into one entry per cell.
    for (genvar i = 0; i < N_CELLS; i++) begin : g_unpack
        assign cls_arr[i] = class_tab[2*i +: 2];
    end

    // Select the class of the captured index.
    always_comb begin
        sel_cls = cls_arr[0];
        for (int i = 0; i < N_CELLS; i++) begin
            if (hit_idx == IDX_W'(i)) sel_cls = cls_arr[i];
        end
    end

    // Register the dispatch pulses and the held error index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            spur_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            act_q  <= (last && hit) ? class_onehot(sel_cls) : '0;
            spur_q <= last && !hit;
            if (last && hit) idx_q <= hit_idx;
        end
    end

    assign act      = act_q;
    assign spurious = spur_q;
    assign err_idx  = idx_q;

endmodule

// File: rtl/aexc_dispatch.sv
// Top of the assertion-chain exception dispatcher. It scans the chain after
// an event, captures the lowest failing cell and dispatches its class as a
// one-hot action pulse. Assumes a chain synchronous to clk.
module aexc_dispatch #(
    parameter  int N_CELLS = 8,
    localparam int IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_n,
    input  logic                 scan_in,
    input  logic [2*N_CELLS-1:0] class_tab,
    output logic                 scan_en_n,
    output logic                 scan_clk,
    output logic [3:0]           act,
    output logic                 spurious,
    output logic [IDX_W-1:0]     err_idx
);
    logic             scanning;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] pos;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    aexc_seq #(.N_CELLS(N_CELLS), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_n     (evt_n),
        .scanning  (scanning),
        .first     (first),
        .last      (last),
        .pos       (pos),
        .scan_en_n (scan_en_n),
        .scan_clk  (scan_clk)
    );

    aexc_capture #(.IDX_W(IDX_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .scanning (scanning),
        .first    (first),
        .pos      (pos),
        .scan_in  (scan_in),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    aexc_encode #(.N_CELLS(N_CELLS), .IDX_W(IDX_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .last      (last),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .class_tab (class_tab),
        .act       (act),
        .spurious  (spurious),
        .err_idx   (err_idx)
    );

endmodule

// File: rtl/aexc_dispatch_chk.sv
// Port-level checker for aexc_dispatch, attached by bind. It counts
// scan-enable run length itself, so the window does not depend on $past depth.
module aexc_dispatch_chk #(
    parameter int N_CELLS = 8,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_n,
    input logic             scan_en_n,
    input logic             scan_clk,
    input logic [3:0]       act,
    input logic             spurious,
    input logic [IDX_W-1:0] err_idx
);
    int run_q;

    // Count consecutive cycles with scan enable active.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 0;
        else        run_q <= scan_en_n ? 0 : run_q + 1;
    end

    AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en_n) |-> run_q == N_CELLS);                            // R2
    AST_SCAN_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en_n) |-> !$past(evt_n));                               // R2
    AST_SCLK_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        scan_clk |-> !scan_en_n);                                          // R3
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_idx) |-> act != 4'b0);                                // R4
    AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act));                                                    // R5
    AST_ACT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        act != 4'b0 |=> act == 4'b0);                                      // R6
    AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en_n) |-> (act != 4'b0) || spurious);                   // R6
    AST_SPUR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |-> act == 4'b0 && $stable(err_idx));                     // R7

endmodule

bind aexc_dispatch aexc_dispatch_chk #(.N_CELLS(N_CELLS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_n     (evt_n),
    .scan_en_n (scan_en_n),
    .scan_clk  (scan_clk),
    .act       (act),
    .spurious  (spurious),
    .err_idx   (err_idx)
);

// File: tb/aexc_dispatch_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the predicted dispatch, and the
// monitor pops and compares it when a scan ends.
module aexc_dispatch_test;
    localparam int N  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            evt_n = 1'b1;
    logic            scan_in;
    logic [2*N-1:0]  class_tab = '0;
    logic            scan_en_n, scan_clk, spurious;
    logic [3:0]      act;
    logic [IW-1:0]   err_idx;

    aexc_dispatch #(.N_CELLS(N)) uut (
        .clk(clk), .rst_n(rst_n), .evt_n(evt_n), .scan_in(scan_in),
        .class_tab(class_tab), .scan_en_n(scan_en_n), .scan_clk(scan_clk),
        .act(act), .spurious(spurious), .err_idx(err_idx)
    );

    // Chain model: loads cell results while idle, shifts on the strobe.
    logic [N-1:0] fail_mask = '0;
    logic [N-1:0] chain_q;
    always @(posedge clk) begin
        if (scan_en_n)     chain_q <= ~fail_mask;
        else if (scan_clk) chain_q <= {1'b1, chain_q[N-1:1]};
    end
    assign scan_in = chain_q[0];

    typedef struct packed {
        logic [3:0]    act;
        logic          spur;
        logic [IW-1:0] idx;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0, scans = 0, k = 0;
    logic [IW-1:0] held_idx = '0;
    bit bad_clk = 0, prev_en = 1, finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int actual, input int expect_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expect_v);
        end
    endtask

    // Predict the dispatch for a failure mask and class table.
    task automatic push_expect(input logic [N-1:0] m, input logic [2*N-1:0] t);
        exp_t e;
        e = '0;
        e.spur = 1'b1;
        e.idx  = held_idx;
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) begin
                e.spur = 1'b0;
                e.idx  = IW'(i);
                e.act  = 4'b1 << t[2*i +: 2];
            end
        end
        held_idx = e.idx;
        exp_q.push_back(e);
    endtask

    // Drive one event: hold evt_n low for hold cycles, then let it settle.
    task automatic run_case(input logic [N-1:0] m, input logic [2*N-1:0] t, input int hold);
        @(negedge clk);
        fail_mask = m;
        class_tab = t;
        push_expect(m, t);
        evt_n = 1'b0;
        repeat (hold) @(negedge clk);
        evt_n = 1'b1;
        repeat (N + 3) @(negedge clk);
    endtask

    // Monitor: scan timing and scoreboard comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_en && !scan_en_n) begin
                scans++;
                k = 0;
                bad_clk = 0;
            end
            if (!scan_en_n) begin
                if (scan_clk != (k < N - 1)) bad_clk = 1;
                k++;
            end
            if (!prev_en && scan_en_n) begin
                chk(k == N, "R2", "scan length", k, N);
                chk(!bad_clk, "R3", "scan_clk pattern", int'(bad_clk), 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "scan end with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(act == e.act, "R5", "act", int'(act), int'(e.act));
                    chk(spurious == e.spur, "R7", "spurious", int'(spurious), int'(e.spur));
                    chk(err_idx == e.idx, "R4", "err_idx", int'(err_idx), int'(e.idx));
                end
            end else if (act != 4'b0 || spurious) begin
                chk(0, "R6", "pulse outside scan end", int'(act), 0);
            end
            prev_en = scan_en_n;
        end
    end

    function automatic logic [2*N-1:0] tab_fwd();
        logic [2*N-1:0] t;
        for (int i = 0; i < N; i++) t[2*i +: 2] = 2'(i % 4);
        return t;
    endfunction

    function automatic logic [2*N-1:0] tab_rev();
        logic [2*N-1:0] t;
        for (int i = 0; i < N; i++) t[2*i +: 2] = 2'(3 - (i % 4));
        return t;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        // R1: outputs in reset
        chk(scan_en_n && !scan_clk && act == 0 && !spurious && err_idx == 0,
            "R1", "reset outputs", int'(act), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(scan_en_n && !scan_clk && act == 0 && !spurious && err_idx == 0,
            "R1", "post-reset outputs", int'(scan_en_n), 1);

        run_case(8'b0000_1000, tab_fwd(), N + 2);          // single failure, class 3
        run_case(8'b0010_0001, tab_fwd(), N + 2);          // R4 lowest of two
        run_case(8'b1000_0000, tab_fwd(), N + 2);          // R4 failure in last cell
        run_case(8'b0000_0000, tab_fwd(), N + 2);          // R7 no failing cell
        run_case(8'b1111_1111, tab_rev(), N + 2);          // all fail, reversed table
        run_case(8'b0000_0100, tab_rev(), N + 2);          // R5 cell 2 class 1
        for (int i = 0; i < N; i++) begin
            run_case(N'(1) << i, tab_fwd(), N + 2);        // R5 every class
        end

        // R8: evt_n held low for a long time gives one scan only
        s0 = scans;
        run_case(8'b0001_0000, tab_rev(), 4 * N);
        chk(scans == s0 + 1, "R8", "scans while held low", scans - s0, 1);

        // R9: evt_n released mid-scan; the scan still completes
        s0 = scans;
        run_case(8'b0100_0000, tab_fwd(), 3);
        chk(scans == s0 + 1, "R9", "scan after mid-scan release", scans - s0, 1);

        // R9: re-arm in the pulse cycle, then an immediate second event
        s0 = scans;
        @(negedge clk);
        fail_mask = 8'b0000_0010;
        class_tab = tab_fwd();
        push_expect(fail_mask, class_tab);
        evt_n = 1'b0;
        repeat (N + 1) @(negedge clk);
        evt_n = 1'b1;
        @(negedge clk);
        fail_mask = 8'b0000_1100;
        push_expect(fail_mask, class_tab);
        evt_n = 1'b0;
        repeat (N + 2) @(negedge clk);
        evt_n = 1'b1;
        repeat (N + 3) @(negedge clk);
        chk(scans == s0 + 2, "R9", "back-to-back scans", scans - s0, 2);

        chk(exp_q.size() == 0, "R6", "unconsumed predictions", exp_q.size(), 0);
        finish_run();
    end

endmodule